// File: doc/BRIEF.md
# Flow-Controlled SPI Link Master

This block is the master end of a two-way SPI link between a local controller and a host processor. It drives the serial clock, the master-out data line and an active-low chip select. Two sideband lines come back from the host. The receipt line (`ack_in`) reports, with a rising edge, that the host has drained the last frame. The request line (`cmd_in`) asks the link to turn around so the host can send a command.

Local agents push channel/data pairs into a small queue. The block sends each pair as a 2-byte frame and then waits for the receipt edge before it sends anything else, which gives the bus the backpressure that plain SPI lacks. When the host raises its request line, the block sends a switch frame and waits for a receipt. It then clocks in a fixed 6-byte command while driving zeros, and after a further receipt it hands the command out on a one-cycle strobe. If the command has a response, the block streams that response back from a byte handshake. A long timeout returns the link to a sane state if the host goes quiet.

Top module: `spi_link_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `cmd_valid` is 0 and `up_ready` is 1. The link starts in the host-off state, in which no frame is sent. It moves to the ready state when the synchronised receipt line is first seen high, so a host that already holds `ack_in` high is detected at once.
- R2: In the ready state with a queued pair, one frame is sent: the channel byte and then the data byte. `cs_n` stays low across both bytes, and data is sent in SPI mode 0, MSB first. The channel codes are keyboard 0x01, mouse 0x02, event 0x03 and switch 0x04.
- R3: After an upstream frame the link waits. No further frame starts until a rising edge on `ack_in` (after two-flop synchronisation) returns it to the ready state.
- R4: In the host-off state no frame is sent. A rising edge on `ack_in` moves the link to the ready state.
- R5: A rising edge on `ack_in` that arrives while the link is in the ready state is ignored. It does not release the frame that follows.
- R6: The push queue holds 4 pairs and `up_ready` is 0 while it is full. A push made while `up_ready` is 0 is dropped. Pairs go out in the order they were pushed.
- R7: In the ready state a high `cmd_in` takes priority over queued pairs. It sends the frame {0x04, 0x00} and moves the link to switch-wait. Queued pairs stay in the queue until the link is back in the ready state.
- R8: In switch-wait, a rising edge on `ack_in` starts a single 6-byte read with MOSI held at 0, and the link then moves to pull-wait.
- R9: In pull-wait, a rising edge on `ack_in` pulses `cmd_valid` for one cycle. The outputs then carry: `cmd_code` from pulled byte 0; `cmd_arglen` from byte 1 bits [7:4]; `cmd_rsplen` from byte 1 bits [3:0]; and `cmd_args` from bytes 2 to 5, with byte 2 in bits [31:24]. A response length of 0 returns the link to the ready state.
- R10: A nonzero response length N sends one frame of N bytes taken through `rsp_valid`/`rsp_ready`, in the order offered. The link then waits as in R3.
- R11: If a waiting state (after an upstream frame, switch-wait or pull-wait) sees no receipt edge for TIMEOUT_CYC cycles, the link goes to the ready state when `ack_in` is high and to host-off when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | output | 1 | SPI serial clock, idles low |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |
| cs_n | output | 1 | Active-low chip select |
| ack_in | input | 1 | Host receipt line, rising edge acknowledges |
| cmd_in | input | 1 | Host request for a command pull |
| up_valid | input | 1 | Upstream pair offered |
| up_ready | output | 1 | Queue can accept a pair |
| up_chan | input | 8 | Channel code of the pair |
| up_data | input | 8 | Data byte of the pair |
| cmd_valid | output | 1 | One-cycle strobe of a pulled command |
| cmd_code | output | 8 | Command code |
| cmd_arglen | output | 4 | Argument length nibble |
| cmd_rsplen | output | 4 | Response length nibble |
| cmd_args | output | 32 | Argument bytes 2..5 |
| rsp_valid | input | 1 | Response byte offered |
| rsp_ready | output | 1 | Response byte taken this cycle |
| rsp_byte | input | 8 | Response byte |

## Verification
The bench builds the block with a half-period divide of 2, a queue of 4 pairs and a timeout of 3000 cycles. The short timeout lets both timeout exits, to the ready state and to host-off, be reached within a few thousand cycles. The small divide keeps the 6-byte pull and the response frames short, so many random upstream frames, a full queue and two complete command exchanges all fit in one run. A bench slave model shifts data on the bus edges, so frame contents and MOSI levels are checked exactly as a host would see them.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam logic [7:0] CH_KEYBOARD = 8'h01;
  localparam logic [7:0] CH_MOUSE    = 8'h02;
  localparam logic [7:0] CH_EVENT    = 8'h03;
  localparam logic [7:0] CH_SWITCH   = 8'h04;
  localparam int unsigned PULL_BYTES = 6;

  typedef enum logic [3:0] {
    LS_HOSTOFF  = 4'd0,
    LS_READY    = 4'd1,
    LS_WAIT     = 4'd2,
    LS_SWWAIT   = 4'd3,
    LS_PULLWAIT = 4'd4,
    LS_TX_UP    = 4'd5,
    LS_TX_SW    = 4'd6,
    LS_TX_PULL  = 4'd7,
    LS_TX_RSP   = 4'd8
  } link_state_e;
endpackage

// File: rtl/spl_sync2.sv
module spl_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end
  assign q = sync_q;
endmodule

// File: rtl/spl_pair_fifo.sv
module spl_pair_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic push_ok, pop_ok;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (push_ok != pop_ok) cnt_q <= push_ok ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spl_byte_engine.sv
module spl_byte_engine #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       last,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          run_q, sclk_q, rxb_q;
  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          tick;

  assign tick    = run_q && (div_q == CW'(HALF_DIV-1));
  assign last    = tick && sclk_q && (bit_q == 3'd7);
  assign rx_byte = {sh_q[6:0], rxb_q};
  assign busy    = run_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      rxb_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else if (start && !run_q) begin
      run_q  <= 1'b1;
      sh_q   <= tx_byte;
      div_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
    end else if (run_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxb_q  <= miso;
        end else begin
          sclk_q <= 1'b0;
          sh_q   <= {sh_q[6:0], rxb_q};
          bit_q  <= bit_q + 1'b1;
          if (bit_q == 3'd7) run_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_link_master.sv
module spi_link_master
  import spl_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int QDEPTH      = 4,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  input  logic        ack_in,
  input  logic        cmd_in,
  input  logic        up_valid,
  output logic        up_ready,
  input  logic [7:0]  up_chan,
  input  logic [7:0]  up_data,
  output logic        cmd_valid,
  output logic [7:0]  cmd_code,
  output logic [3:0]  cmd_arglen,
  output logic [3:0]  cmd_rsplen,
  output logic [31:0] cmd_args,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_byte
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int PW = 8 * PULL_BYTES;

  link_state_e st_q, st_d;
  logic ack_s, ack_d_q, cmd_s, ack_rise;
  logic q_full, q_empty, q_pop;
  logic [15:0] q_head;
  logic [7:0] fr_chan_q, fr_data_q;
  logic [3:0] idx_q, frame_len;
  logic [PW-1:0] pull_q;
  logic [TW-1:0] tmo_q;
  logic in_tx, in_wait, tmo_hit, tx_done, byte_avail;
  logic eng_start, eng_busy, eng_last;
  logic [7:0] eng_tx, eng_rx;
  logic cmd_fire, cmd_valid_q;

  spl_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s));
  spl_sync2 u_cmd_sync (.clk(clk), .rst_n(rst_n), .d(cmd_in), .q(cmd_s));

  spl_pair_fifo #(.DEPTH(QDEPTH), .W(16)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(up_valid), .din({up_chan, up_data}),
    .pop(q_pop), .dout(q_head), .full(q_full), .empty(q_empty));

  spl_byte_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx), .miso(miso),
    .busy(eng_busy), .last(eng_last), .rx_byte(eng_rx), .sclk(sclk), .mosi(mosi));

  assign ack_rise   = ack_s && !ack_d_q;
  assign up_ready   = !q_full;
  assign in_tx      = st_q inside {LS_TX_UP, LS_TX_SW, LS_TX_PULL, LS_TX_RSP};
  assign in_wait    = st_q inside {LS_WAIT, LS_SWWAIT, LS_PULLWAIT};
  assign tmo_hit    = in_wait && (tmo_q == TW'(TIMEOUT_CYC - 1));
  assign cs_n       = !in_tx;
  assign cmd_code   = pull_q[PW-1 -: 8];
  assign cmd_arglen = pull_q[PW-9 -: 4];
  assign cmd_rsplen = pull_q[PW-13 -: 4];
  assign cmd_args   = pull_q[31:0];
  assign cmd_valid  = cmd_valid_q;

  // per-frame byte source and length
  always_comb begin
    frame_len  = 4'd2;
    eng_tx     = 8'h00;
    byte_avail = 1'b1;
    unique case (st_q)
      LS_TX_UP:   eng_tx = (idx_q == 4'd0) ? fr_chan_q : fr_data_q;
      LS_TX_SW:   eng_tx = (idx_q == 4'd0) ? CH_SWITCH : 8'h00;
      LS_TX_PULL: frame_len = 4'(PULL_BYTES);
      LS_TX_RSP: begin
        frame_len  = cmd_rsplen;
        eng_tx     = rsp_byte;
        byte_avail = rsp_valid;
      end
      default: ;
    endcase
  end

  assign eng_start = in_tx && !eng_busy && (idx_q < frame_len) && byte_avail;
  assign rsp_ready = eng_start && (st_q == LS_TX_RSP);
  assign tx_done   = in_tx && !eng_busy && (idx_q == frame_len);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    q_pop    = 1'b0;
    cmd_fire = 1'b0;
    unique case (st_q)
      LS_HOSTOFF: if (ack_rise) st_d = LS_READY;
      LS_READY: begin
        if (cmd_s) st_d = LS_TX_SW;
        else if (!q_empty) begin
          st_d  = LS_TX_UP;
          q_pop = 1'b1;
        end
      end
      LS_WAIT: begin
        if (ack_rise) st_d = LS_READY;
        else if (tmo_hit) st_d = ack_s ? LS_READY : LS_HOSTOFF;
      end
      LS_SWWAIT: begin
        if (ack_rise) st_d = LS_TX_PULL;
        else if (tmo_hit) st_d = ack_s ? LS_READY : LS_HOSTOFF;
      end
      LS_PULLWAIT: begin
        if (ack_rise) begin
          cmd_fire = 1'b1;
          st_d = (cmd_rsplen == 4'd0) ? LS_READY : LS_TX_RSP;
        end else if (tmo_hit) st_d = ack_s ? LS_READY : LS_HOSTOFF;
      end
      LS_TX_UP:   if (tx_done) st_d = LS_WAIT;
      LS_TX_SW:   if (tx_done) st_d = LS_SWWAIT;
      LS_TX_PULL: if (tx_done) st_d = LS_PULLWAIT;
      LS_TX_RSP:  if (tx_done) st_d = LS_WAIT;
      default:    st_d = LS_HOSTOFF;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= LS_HOSTOFF;
      ack_d_q     <= 1'b0;
      idx_q       <= '0;
      fr_chan_q   <= '0;
      fr_data_q   <= '0;
      pull_q      <= '0;
      tmo_q       <= '0;
      cmd_valid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      ack_d_q     <= ack_s;
      cmd_valid_q <= cmd_fire;
      tmo_q       <= in_wait ? tmo_q + 1'b1 : '0;
      if (!in_tx) idx_q <= '0;
      else if (eng_last) idx_q <= idx_q + 1'b1;
      if (q_pop) begin
        fr_chan_q <= q_head[15:8];
        fr_data_q <= q_head[7:0];
      end
      if (eng_last && (st_q == LS_TX_PULL)) pull_q <= {pull_q[PW-9:0], eng_rx};
    end
  end
endmodule

// File: rtl/spl_checker.sv
module spl_checker
  import spl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic       cmd_valid,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [3:0] st
);
  // R2: the clock only toggles inside a frame
  assert_sclk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R2: mode 0, data held while clock is high
  assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R3: a frame begins only from ready, switch-wait or pull-wait
  assert_frame_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(st) == LS_READY || $past(st) == LS_SWWAIT ||
                     $past(st) == LS_PULLWAIT));

  // R9: command strobe lasts one cycle
  assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R10: a response byte is taken only when offered
  assert_rsp_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> rsp_valid);
endmodule

bind spi_link_master spl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .cmd_valid(cmd_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .st(st_q));

// File: tb/tb_spi_link_master.sv
`timescale 1ns/1ps
module tb_spi_link_master;
  localparam int TMO = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk, mosi, cs_n, up_ready, cmd_valid, rsp_ready;
  logic miso = 1'b0, ack_in = 1'b0, cmd_in = 1'b0, up_valid = 1'b0, rsp_valid = 1'b1;
  logic [7:0] up_chan = 8'h00, up_data = 8'h00, rsp_byte;
  logic [7:0] cmd_code;
  logic [3:0] cmd_arglen, cmd_rsplen;
  logic [31:0] cmd_args;

  always #2 clk = ~clk;

  spi_link_master #(.HALF_DIV(2), .QDEPTH(4), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .ack_in(ack_in), .cmd_in(cmd_in), .up_valid(up_valid), .up_ready(up_ready),
    .up_chan(up_chan), .up_data(up_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_arglen(cmd_arglen), .cmd_rsplen(cmd_rsplen), .cmd_args(cmd_args),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte));

  int n_chk = 0, n_bad = 0;

  // slave model
  logic [7:0] stx[$];
  logic [7:0] cur[$];
  logic [7:0] fbytes[$];
  int flen[$];
  logic [7:0] s_byte = 8'h00, rsh = 8'h00;
  int bitn = 0;
  always @(negedge sclk or negedge cs_n) begin
    if (bitn == 0) s_byte = (stx.size() > 0) ? stx.pop_front() : 8'h00;
    miso = s_byte[7-bitn];
  end
  always @(posedge sclk) begin
    rsh = {rsh[6:0], mosi};
    bitn++;
    if (bitn == 8) begin cur.push_back(rsh); bitn = 0; end
  end
  always @(posedge cs_n) begin
    if (cur.size() > 0) begin
      foreach (cur[i]) fbytes.push_back(cur[i]);
      flen.push_back(cur.size());
      cur.delete();
    end
  end

  // command executor model
  logic [7:0] rbytes [4] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
  int ridx = 0;
  assign rsp_byte = rbytes[ridx[1:0]];
  always @(posedge clk) if (rsp_ready) ridx <= ridx + 1;
  int n_cmd = 0;
  logic [7:0] cap_code; logic [3:0] cap_al, cap_rl; logic [31:0] cap_args;
  always @(posedge clk) if (cmd_valid) begin
    n_cmd <= n_cmd + 1;
    cap_code <= cmd_code; cap_al <= cmd_arglen; cap_rl <= cmd_rsplen; cap_args <= cmd_args;
  end

  function automatic logic [31:0] exp_args(input logic [7:0] b2, b3, b4, b5);
    return {b2, b3, b4, b5};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_ack;
    @(negedge clk); ack_in = 1'b0; cyc(4); ack_in = 1'b1; cyc(4);
  endtask

  task automatic push_pair(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_valid = 1'b1; up_chan = c; up_data = d;
    @(negedge clk); up_valid = 1'b0;
  endtask

  task automatic expect_frame(input string req, input logic [7:0] e[$]);
    int t = 0;
    while (flen.size() == 0 && t < 2000) begin @(negedge clk); t++; end
    if (flen.size() == 0) begin
      chk(1'b0, req, "frame missing", 0, e.size());
    end else begin
      int n = flen.pop_front();
      chk(n == e.size(), req, "frame length", n, e.size());
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = fbytes.pop_front();
        if (i < e.size()) chk(b == e[i], req, $sformatf("byte %0d", i), b, e[i]);
      end
    end
  endtask

  task automatic expect_quiet(input string req, input int n);
    cyc(n);
    chk(flen.size() == 0 && cs_n, req, "no frame expected", flen.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'h1F2E3D4C);
    logic [7:0] c, d;
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk", sclk, 0);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid", cmd_valid, 0);
    chk(up_ready == 1'b1, "R1", "up_ready", up_ready, 1);

    // R4 host-off holds frames until ack rises
    push_pair(8'h01, 8'h11);
    expect_quiet("R4", 300);
    @(negedge clk); ack_in = 1'b1;
    expect_frame("R4", '{8'h01, 8'h11});

    // R3 wait until receipt edge
    push_pair(8'h02, 8'h22);
    expect_quiet("R3", 300);
    pulse_ack();
    expect_frame("R3", '{8'h02, 8'h22});

    // R2 random frames in push order
    for (int k = 0; k < 16; k++) begin
      c = 8'(1 + ($urandom % 3)); d = 8'($urandom);
      pulse_ack();
      push_pair(c, d);
      expect_frame("R2", '{c, d});
    end

    // R6 full queue, dropped push, order kept
    for (int k = 0; k < 4; k++) push_pair(8'h03, 8'(8'hA0 + k));
    cyc(1);
    chk(up_ready == 1'b0, "R6", "up_ready when full", up_ready, 0);
    @(negedge clk); up_valid = 1'b1; up_chan = 8'h01; up_data = 8'hEE;
    @(negedge clk); up_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pulse_ack();
      expect_frame("R6", '{8'h03, 8'(8'hA0 + k)});
    end
    pulse_ack();
    expect_quiet("R6", 300);

    // R5 edge in ready state does not pre-acknowledge
    pulse_ack();
    push_pair(8'h02, 8'h51);
    push_pair(8'h02, 8'h52);
    expect_frame("R5", '{8'h02, 8'h51});
    expect_quiet("R5", 300);
    pulse_ack();
    expect_frame("R5", '{8'h02, 8'h52});
    pulse_ack();

    // R7/R8/R9 command with no response
    @(negedge clk); cmd_in = 1'b1;
    expect_frame("R7", '{8'h04, 8'h00});
    push_pair(8'h01, 8'h77);
    expect_quiet("R7", 200);
    stx = '{8'h5A, 8'h40, 8'h11, 8'h22, 8'h33, 8'h44};
    pulse_ack();
    expect_frame("R8", '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    chk(n_cmd == 0, "R8", "no strobe before receipt", n_cmd, 0);
    @(negedge clk); cmd_in = 1'b0;
    pulse_ack();
    chk(n_cmd == 1, "R9", "strobe count", n_cmd, 1);
    chk(cap_code == 8'h5A, "R9", "code", cap_code, 8'h5A);
    chk(cap_al == 4'h4, "R9", "arglen", cap_al, 4);
    chk(cap_rl == 4'h0, "R9", "rsplen", cap_rl, 0);
    chk(cap_args == exp_args(8'h11, 8'h22, 8'h33, 8'h44), "R9", "args", cap_args,
        exp_args(8'h11, 8'h22, 8'h33, 8'h44));
    expect_frame("R9", '{8'h01, 8'h77});

    // R7 priority over queued pair, R10 response frame
    push_pair(8'h03, 8'h55);
    @(negedge clk); cmd_in = 1'b1;
    pulse_ack();
    expect_frame("R7", '{8'h04, 8'h00});
    stx = '{8'hA5, 8'h23, 8'h01, 8'h02, 8'h03, 8'h04};
    pulse_ack();
    expect_frame("R8", '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    @(negedge clk); cmd_in = 1'b0;
    pulse_ack();
    chk(cap_rl == 4'h3, "R10", "rsplen", cap_rl, 3);
    expect_frame("R10", '{8'hC1, 8'hC2, 8'hC3});
    expect_quiet("R10", 200);
    pulse_ack();
    expect_frame("R7", '{8'h03, 8'h55});

    // R11 timeout with ack high
    expect_quiet("R11", 1000);
    push_pair(8'h01, 8'h99);
    expect_quiet("R11", 1000);
    expect_frame("R11", '{8'h01, 8'h99});

    // R11 timeout with ack low goes host-off
    @(negedge clk); ack_in = 1'b0;
    cyc(TMO + 100);
    push_pair(8'h02, 8'h98);
    expect_quiet("R11", 400);
    @(negedge clk); ack_in = 1'b1;
    expect_frame("R11", '{8'h02, 8'h98});

    cyc(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule